// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

This block is a binary down counter with a single terminal-count flag. All of its controls and its flag are active low. While counting is enabled, each rising clock edge lowers the count by one. When the count reaches zero it wraps to all ones, so a stage that runs freely repeats every 2^WIDTH clocks. The count can be loaded from a preset word in two ways. The synchronous way loads on a clock edge. The asynchronous way loads at once and keeps following the word while it is held. A master reset sets the count to all ones at any time.

The flag goes low only when the count is zero and counting is enabled. To make a longer counter, place several stages side by side on one clock and feed each stage's flag into the count-enable input of the next stage. The upper stage then steps only at the instant the lower stage wraps. Two 8-bit stages therefore form a counter with a cycle of 65536 clocks. The count register is a row of flops with asynchronous set and clear. The set and clear of each bit are computed from the reset, the asynchronous load and that bit of the preset word.

Top module: `presettable_down_counter`

## Requirements
- R1: While `cnt_hold_n` is 0, `sync_load_n` is 1 and no asynchronous control is active, each rising edge of `clk` lowers `count_q` by one.
- R2: While `cnt_hold_n` is 1 and no load or reset is active, `count_q` keeps its value across clock edges.
- R3: If `sync_load_n` is 0 at a rising edge, `count_q` takes `load_word` on that edge whatever the level of `cnt_hold_n`.
- R4: While `async_load_n` is 0, `count_q` equals `load_word` without waiting for a clock edge and follows any change of `load_word`. This holds regardless of `clk`, `sync_load_n` and `cnt_hold_n`.
- R5: While `rst_max_n` is 0, `count_q` is all ones (255 at the default width) without waiting for a clock edge. This overrides every other input, including `async_load_n`.
- R6: `zero_n` is 0 exactly when `count_q` is 0 and `cnt_hold_n` is 0, and it is 1 otherwise.
- R7: Counting down from 0 gives all ones on the next edge. With counting enabled and no load, `zero_n` goes low once every 256 clocks at the default width.
- R8: When the `zero_n` of one stage drives the `cnt_hold_n` of a second stage on the same clock, the second stage decrements only on edges where the first stage is at zero. The 16-bit pair then passes from all ones to zero in 65535 clocks and wraps to all ones on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge count clock |
| rst_max_n | input | 1 | Asynchronous master reset, active low, forces all ones |
| async_load_n | input | 1 | Asynchronous preset, active low, forces `load_word` |
| sync_load_n | input | 1 | Synchronous preset, active low, loads `load_word` at the edge |
| cnt_hold_n | input | 1 | Count enable and cascade input, active low |
| load_word | input | WIDTH | Preset value |
| zero_n | output | 1 | Terminal-count flag, active low |
| count_q | output | WIDTH | Present count |

## Verification
A long run of seeded random control patterns mixes reset, both kinds of load, hold and count. It is compared edge by edge with a bench model, so a wrong precedence between two active controls shows up as a mismatch. A directed sweep drives all sixteen control combinations in turn, which isolates each precedence pair. A mid-cycle change of the preset word while the asynchronous load is held separates true immediate loading from loading that waits for the clock. A free run from all ones checks the wrap and the 256-clock flag period. A full 65536-clock run of a two-stage chain checks that the upper stage steps only when the lower stage wraps.

// File: rtl/pdc_pkg.sv
// Package: shared width default and the control-mode type used to pick the
// next count. Assumes every counter stage uses the same width.
package pdc_pkg;
    parameter int unsigned CNT_W = 8;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_DEC  = 2'd1,
        MODE_LOAD = 2'd2
    } pdc_mode_e;
endpackage

// File: rtl/pdc_async_ctl.sv
// Module: pdc_async_ctl
// Turns the master reset and the asynchronous preset into a set and a clear
// strobe for each bit of the count. Reset wins: it asserts every set and masks
// every clear. Assumes the strobes feed flops with set priority over clear.
module pdc_async_ctl #(
    parameter int unsigned WIDTH = pdc_pkg::CNT_W
) (
    input  logic             rst_max_n,
    input  logic             async_load_n,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] set_n,
    output logic [WIDTH-1:0] clr_n
);
    // Per-bit strobe derivation from reset and the preset word.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            set_n[i] = ~(~rst_max_n | (~async_load_n & load_word[i]));
            clr_n[i] = ~(rst_max_n & ~async_load_n & ~load_word[i]);
        end
    end
endmodule

// File: rtl/pdc_next.sv
// Module: pdc_next
// Picks the value the count takes at the next clock edge. A synchronous load
// beats the count enable, and with neither of them active the count holds.
// Assumes the asynchronous controls are handled in the flops themselves.
module pdc_next #(
    parameter int unsigned WIDTH = pdc_pkg::CNT_W
) (
    input  logic             sync_load_n,
    input  logic             cnt_hold_n,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] nxt
);
    import pdc_pkg::*;

    pdc_mode_e mode;

    // Mode selection by fixed precedence.
    always_comb begin
        if (!sync_load_n)     mode = MODE_LOAD;
        else if (!cnt_hold_n) mode = MODE_DEC;
        else                  mode = MODE_HOLD;
    end

    // Next-value multiplexer; subtraction wraps modulo 2^WIDTH.
    always_comb begin
        case (mode)
            MODE_LOAD: nxt = load_word;
            MODE_DEC:  nxt = cur - WIDTH'(1);
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/pdc_cell.sv
// Module: pdc_cell
// One count bit: a rising-edge flop with asynchronous active-low set and
// clear. Set has priority over clear. Assumes both strobes are glitch-safe
// at the chip level.
module pdc_cell (
    input  logic clk,
    input  logic set_n,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    // Storage with asynchronous overrides.
    always_ff @(posedge clk or negedge set_n or negedge clr_n) begin
        if (!set_n)      q <= 1'b1;
        else if (!clr_n) q <= 1'b0;
        else             q <= d;
    end
endmodule

// File: rtl/pdc_zero_flag.sv
// Module: pdc_zero_flag
// Active-low terminal-count decode: low only at zero count while counting is
// enabled. Assumes the output may drive the next stage's count enable.
module pdc_zero_flag #(
    parameter int unsigned WIDTH = pdc_pkg::CNT_W
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             cnt_hold_n,
    output logic             zero_n
);
    // Zero detection gated by the count enable.
    always_comb zero_n = ~((cur == '0) & ~cnt_hold_n);
endmodule

// File: rtl/presettable_down_counter.sv
// Module: presettable_down_counter
// Down counter stage with synchronous and asynchronous preset, master reset
// to all ones and a gated terminal-count flag for cascading. Assumes all
// cascaded stages share clk.
module presettable_down_counter #(
    parameter int unsigned WIDTH = pdc_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_max_n,
    input  logic             async_load_n,
    input  logic             sync_load_n,
    input  logic             cnt_hold_n,
    input  logic [WIDTH-1:0] load_word,
    output logic             zero_n,
    output logic [WIDTH-1:0] count_q
);
    logic [WIDTH-1:0] set_n;
    logic [WIDTH-1:0] clr_n;
    logic [WIDTH-1:0] nxt;

    pdc_async_ctl #(.WIDTH(WIDTH)) u_async (
        .rst_max_n    (rst_max_n),
        .async_load_n (async_load_n),
        .load_word    (load_word),
        .set_n        (set_n),
        .clr_n        (clr_n)
    );

    pdc_next #(.WIDTH(WIDTH)) u_next (
        .sync_load_n (sync_load_n),
        .cnt_hold_n  (cnt_hold_n),
        .cur         (count_q),
        .load_word   (load_word),
        .nxt         (nxt)
    );

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        pdc_cell u_cell (
            .clk   (clk),
            .set_n (set_n[g]),
            .clr_n (clr_n[g]),
            .d     (nxt[g]),
            .q     (count_q[g])
        );
    end

    pdc_zero_flag #(.WIDTH(WIDTH)) u_zero (
        .cur        (count_q),
        .cnt_hold_n (cnt_hold_n),
        .zero_n     (zero_n)
    );
endmodule

// File: rtl/pdc_checker.sv
// Module: pdc_checker
// Temporal checks on a counter stage, bound to every instance.
module pdc_checker #(
    parameter int unsigned WIDTH = pdc_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst_max_n,
    input logic             async_load_n,
    input logic             sync_load_n,
    input logic             cnt_hold_n,
    input logic [WIDTH-1:0] load_word,
    input logic             zero_n,
    input logic [WIDTH-1:0] count_q
);
    p_dec_r1: assert property (@(posedge clk) disable iff (!rst_max_n)
        (async_load_n && sync_load_n && !cnt_hold_n) |=>
        (!async_load_n || count_q == WIDTH'($past(count_q) - WIDTH'(1))));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_max_n)
        (async_load_n && sync_load_n && cnt_hold_n) |=>
        (!async_load_n || count_q == $past(count_q)));

    p_sload_r3: assert property (@(posedge clk) disable iff (!rst_max_n)
        (async_load_n && !sync_load_n) |=>
        (!async_load_n || count_q == $past(load_word)));

    p_aload_r4: assert property (@(posedge clk) disable iff (!rst_max_n)
        !async_load_n |-> (count_q == load_word));

    p_reset_r5: assert property (@(posedge clk)
        !rst_max_n |-> (count_q == '1));

    p_flag_idle_r6: assert property (@(posedge clk) disable iff (!rst_max_n)
        (cnt_hold_n || count_q != '0) |-> zero_n);

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_max_n)
        (async_load_n && sync_load_n && !cnt_hold_n && count_q == '0) |=>
        (!async_load_n || count_q == '1));
endmodule

bind presettable_down_counter pdc_checker #(.WIDTH(WIDTH)) u_pdc_checker (.*);

// File: tb/test_presettable_down_counter.sv
module test_presettable_down_counter;
    logic       clk = 1'b0;
    logic       rst_max_n = 1'b1;
    logic       async_load_n = 1'b1;
    logic       sync_load_n = 1'b1;
    logic       cnt_hold_n = 1'b1;
    logic [7:0] load_word = 8'h00;
    logic       zero_n;
    logic [7:0] count_q;
    logic       hi_zero_n;
    logic [7:0] hi_q;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_lo;
    logic [7:0] exp_hi;
    string      last_tag;

    always #4 clk = ~clk;

    presettable_down_counter i_presettable_down_counter (
        .clk (clk), .rst_max_n (rst_max_n), .async_load_n (async_load_n),
        .sync_load_n (sync_load_n), .cnt_hold_n (cnt_hold_n),
        .load_word (load_word), .zero_n (zero_n), .count_q (count_q)
    );

    presettable_down_counter i_presettable_down_counter_hi (
        .clk (clk), .rst_max_n (rst_max_n), .async_load_n (1'b1),
        .sync_load_n (1'b1), .cnt_hold_n (zero_n),
        .load_word (8'h00), .zero_n (hi_zero_n), .count_q (hi_q)
    );

    function automatic logic flag_of(input logic [7:0] c, input logic hold);
        return !(c == 8'h00 && !hold);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: check the edge result, drive new inputs, check async effects.
    task automatic step(input logic r, input logic a, input logic s,
                        input logic h, input logic [7:0] w);
        logic zl;
        @(negedge clk);
        chk(last_tag, {8'h00, count_q}, {8'h00, exp_lo});
        chk("R8", {8'h00, hi_q}, {8'h00, exp_hi});
        rst_max_n = r; async_load_n = a; sync_load_n = s;
        cnt_hold_n = h; load_word = w;
        #1;
        if (!r) begin exp_lo = 8'hFF; exp_hi = 8'hFF; end
        else if (!a) exp_lo = w;
        zl = flag_of(exp_lo, h);
        chk(!r ? "R5" : (!a ? "R4" : "R6"), {8'h00, count_q}, {8'h00, exp_lo});
        chk("R6", {15'd0, zero_n}, {15'd0, zl});
        chk("R8", {15'd0, hi_zero_n}, {15'd0, flag_of(exp_hi, zl)});
        @(posedge clk);
        if (!r)        last_tag = "R5";
        else if (!a)   last_tag = "R4";
        else if (!s)   last_tag = "R3";
        else if (!h)   last_tag = (exp_lo == 8'h00) ? "R7" : "R1";
        else           last_tag = "R2";
        if (r) begin
            if (!zl) exp_hi = exp_hi - 8'd1;
            if (a) begin
                if (!s)      exp_lo = w;
                else if (!h) exp_lo = exp_lo - 8'd1;
            end
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int first_z;
        int prev_z;
        void'($urandom(32'h1D0C));
        exp_lo = 8'hFF; exp_hi = 8'hFF; last_tag = "R5";
        #1 rst_max_n = 1'b0;
        // R5: reset state
        step(0, 1, 1, 1, 8'h00);
        step(1, 1, 1, 1, 8'h00);
        chk("R5", {hi_q, count_q}, 16'hFFFF);

        // R3: synchronous load ignores the hold level
        step(1, 1, 0, 1, 8'h12);
        step(1, 1, 0, 0, 8'h34);
        step(1, 1, 1, 1, 8'h00);
        chk("R3", {8'h00, count_q}, 16'h0034);

        // R4: the count follows the preset word inside one clock period
        @(negedge clk);
        cnt_hold_n = 1'b1; async_load_n = 1'b0; load_word = 8'h5A;
        #1 chk("R4", {8'h00, count_q}, 16'h005A);
        #1 load_word = 8'hC3;
        #1 chk("R4", {8'h00, count_q}, 16'h00C3);
        exp_lo = 8'hC3; last_tag = "R4";
        step(1, 0, 0, 0, 8'hC3);
        step(1, 1, 1, 1, 8'h00);

        // R5 over R4 over R3 over R1: all sixteen control combinations
        for (int c = 0; c < 16; c++) begin
            step(c[3], c[2], c[1], c[0], 8'($urandom));
            step(1, 1, 0, 1, 8'($urandom));
        end

        // R7: free run from all ones, zero flag every 256 clocks
        step(0, 1, 1, 1, 8'h00);
        first_z = -1; prev_z = -1;
        for (int k = 0; k < 600; k++) begin
            step(1, 1, 1, 0, 8'h00);
            if (!zero_n) begin
                if (first_z < 0) first_z = k;
                else if (prev_z < 0) prev_z = k;
            end
        end
        chk("R7", 16'(first_z), 16'd255);
        chk("R7", 16'(prev_z - first_z), 16'd256);

        // Random mix checked against the model
        for (int k = 0; k < 3000; k++) begin
            int u;
            u = int'($urandom_range(0, 99));
            step(u >= 3, $urandom_range(0, 15) != 0, $urandom_range(0, 7) != 0,
                 $urandom_range(0, 3) == 0, 8'($urandom));
        end

        // R8: two-stage chain, 65535 clocks down to zero then wrap
        step(0, 1, 1, 1, 8'h00);
        first_z = -1;
        for (int k = 0; k < 65536; k++) begin
            step(1, 1, 1, 0, 8'h00);
            if (!hi_zero_n && first_z < 0) first_z = k;
        end
        chk("R8", 16'(first_z), 16'd65535);
        step(1, 1, 1, 1, 8'h00);
        chk("R8", {hi_q, count_q}, 16'hFFFF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule